// File: doc/BRIEF.md
# Double-Data-Rate Input Capture and Alignment

This block takes a narrow bus on which the source launches one bit per lane on each edge of a fast capture clock. It turns that bus into two ordinary words: one holds the bits taken on the rising edge and one holds the bits taken on the falling edge. At the capture clock rate a falling-edge sample leaves downstream rising-edge logic only half a period. For that reason the block can present the two words in three alignments. In the first, the falling word stays on its own edge. In the second, the falling sample is retimed to the rising edge inside the block. In the third, the rising word is also delayed one stage, so that both words belong to the same capture cycle.

A packing stage then joins two consecutive same-cycle sample pairs into one word of four times the lane count, with a one-cycle valid strobe on every second cycle. A consumer running at half the capture rate can take this word without ever seeing the fast edge. The alignment mode is latched while reset is held. All storage is plain flip-flops clocked by the capture clock on either edge.

Top module: `ddrCapture`

## Requirements
- R1: In the opposite-edge mode (select 00) and the same-edge mode (select 01), riseWord changes on a rising edge to the lane values sampled at that same edge.
- R2: In the opposite-edge mode, fallWord changes on the falling edge to the lane values sampled at that falling edge, and holds through the following rising edge.
- R3: In the same-edge mode, fallWord changes only on rising edges. After a rising edge it shows the values sampled at the falling edge just before it, so the falling value shown belongs to the previous cycle.
- R4: In the same-edge-pipelined mode (select 10), both words change only on rising edges. After a rising edge they show the rising and falling samples of the preceding capture cycle together.
- R5: When packValid is high, packWord holds two consecutive same-cycle pairs, oldest first from bit 0: first rising sample in bits [N-1:0], first falling in [2N-1:N], second rising in [3N-1:2N], second falling in [4N-1:3N]. packValid is high for exactly one cycle and never in two consecutive cycles.
- R6: After reset is released, the first packed pair is the one captured at the first rising edge with reset low. packValid first rises after the third such rising edge in the opposite-edge mode and after the fourth in the two same-edge modes.
- R7: The mode select is latched only on rising edges while reset is high. A change outside reset has no effect until the next reset. Select 11 behaves as the opposite-edge mode.
- R8: While reset is high, riseWord, fallWord, packWord and packValid are cleared to zero, and the packing phase restarts at the low half.
- R9: Between strobes packWord keeps the last packed value (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; both edges sample data |
| rst | input | 1 | Active-high reset, synchronous to clk |
| ddrIn | input | LANES | Double-data-rate input lanes |
| modeSel | input | 2 | Alignment mode: 00 opposite-edge, 01 same-edge, 10 same-edge-pipelined, 11 as 00 |
| riseWord | output | LANES | Rising-edge sample word |
| fallWord | output | LANES | Falling-edge sample word |
| packWord | output | 4*LANES | Two packed sample pairs, oldest at bit 0 |
| packValid | output | 1 | One-cycle strobe marking a new packWord |

## Verification
The bench checks fallWord after every falling edge as well as after every rising edge. In the opposite-edge mode a retiming flop left on the path shows up as the falling word lagging half a period. In the same-edge modes a missing retime flop shows up as the falling word moving at the falling edge. The bench checks the first strobe after reset in every mode: a packer that ignored the pipeline fill would pack the zeroed registers, and one that failed to restart its phase would put the first pair in the high half. It also changes the mode select in mid-run and uses select 11. A design that decoded the live select, or mishandled the spare code, would switch alignment at once.

// File: rtl/ddrCapPkg.sv
package ddrCapPkg;

  typedef enum logic [1:0] {
    ALIGN_OPPOSITE = 2'b00,
    ALIGN_SAME     = 2'b01,
    ALIGN_PIPED    = 2'b10
  } alignMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic oppEdge;    // falling word taken straight from the falling-edge flop
    logic pipeRise;   // rising word delayed one rising-edge stage
    logic takePair;   // packer accepts the current same-cycle pair
    logic upperHalf;  // accepted pair completes the packed word
  } ctrlStrobe_t;

  localparam int FILL_CNT_W = 2;

  function automatic alignMode_t decodeMode(input logic [1:0] sel);
    case (sel)
      2'b01:   return ALIGN_SAME;
      2'b10:   return ALIGN_PIPED;
      default: return ALIGN_OPPOSITE;
    endcase
  endfunction

  // rising edges after release before the first same-cycle pair reaches the packer
  function automatic logic [FILL_CNT_W-1:0] fillLatency(input alignMode_t m);
    return (m == ALIGN_OPPOSITE) ? FILL_CNT_W'(1) : FILL_CNT_W'(2);
  endfunction

endpackage

// File: rtl/ddrCapCtrl.sv
module ddrCapCtrl
  import ddrCapPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  modeSel,
  output alignMode_t  lockedMode,
  output ctrlStrobe_t strobe
);

  localparam logic [FILL_CNT_W-1:0] FILL_MAX = FILL_CNT_W'(2);

  logic [FILL_CNT_W-1:0] fillCnt;
  logic                  phaseHi;
  logic                  pairReady;

  assign pairReady = !rst && (fillCnt >= fillLatency(lockedMode));

  always_ff @(posedge clk) begin
    if (rst) begin
      lockedMode <= decodeMode(modeSel);
      fillCnt    <= '0;
      phaseHi    <= 1'b0;
    end else begin
      if (fillCnt != FILL_MAX) fillCnt <= fillCnt + FILL_CNT_W'(1);
      if (pairReady) phaseHi <= ~phaseHi;
    end
  end

  always_comb begin
    strobe.oppEdge   = (lockedMode == ALIGN_OPPOSITE);
    strobe.pipeRise  = (lockedMode == ALIGN_PIPED);
    strobe.takePair  = pairReady;
    strobe.upperHalf = phaseHi;
  end

endmodule

// File: rtl/ddrCapPacker.sv
module ddrCapPacker #(
  parameter int LANES = 8,
  localparam int PAIR_W = 2 * LANES,
  localparam int PACK_W = 2 * PAIR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              takePair,
  input  logic              upperHalf,
  input  logic [LANES-1:0]  pairRise,
  input  logic [LANES-1:0]  pairFall,
  output logic [PACK_W-1:0] packWord,
  output logic              packValid
);

  logic [PAIR_W-1:0] holdLow;
  logic [PAIR_W-1:0] pairNow;

  assign pairNow = {pairFall, pairRise};

  always_ff @(posedge clk) begin
    if (rst) begin
      holdLow   <= '0;
      packWord  <= '0;
      packValid <= 1'b0;
    end else begin
      packValid <= takePair && upperHalf;
      if (takePair) begin
        if (upperHalf) packWord <= {pairNow, holdLow};
        else           holdLow  <= pairNow;
      end
    end
  end

endmodule

// File: rtl/ddrCapDatapath.sv
module ddrCapDatapath
  import ddrCapPkg::*;
#(
  parameter int LANES = 8,
  localparam int PACK_W = 4 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  ddrIn,
  input  ctrlStrobe_t       strobe,
  output logic [LANES-1:0]  riseWord,
  output logic [LANES-1:0]  fallWord,
  output logic [PACK_W-1:0] packWord,
  output logic              packValid
);

  logic [LANES-1:0] riseCap;
  logic [LANES-1:0] fallCap;
  logic [LANES-1:0] fallRetimed;
  logic [LANES-1:0] riseDelayed;
  logic [LANES-1:0] pairRise;
  logic [LANES-1:0] pairFall;

  always_ff @(posedge clk) begin
    if (rst) riseCap <= '0;
    else     riseCap <= ddrIn;
  end

  always_ff @(negedge clk) begin
    if (rst) fallCap <= '0;
    else     fallCap <= ddrIn;
  end

  // retime stage for the falling sample and matching delay for the rising one
  always_ff @(posedge clk) begin
    if (rst) begin
      fallRetimed <= '0;
      riseDelayed <= '0;
    end else begin
      fallRetimed <= fallCap;
      riseDelayed <= riseCap;
    end
  end

  genvar lane;
  generate
    for (lane = 0; lane < LANES; lane++) begin : g_laneSel
      assign riseWord[lane] = strobe.pipeRise ? riseDelayed[lane] : riseCap[lane];
      assign fallWord[lane] = strobe.oppEdge  ? fallCap[lane]     : fallRetimed[lane];
      assign pairRise[lane] = strobe.oppEdge  ? riseCap[lane]     : riseDelayed[lane];
      assign pairFall[lane] = strobe.oppEdge  ? fallCap[lane]     : fallRetimed[lane];
    end
  endgenerate

  ddrCapPacker #(.LANES(LANES)) u_packer (
    .clk       (clk),
    .rst       (rst),
    .takePair  (strobe.takePair),
    .upperHalf (strobe.upperHalf),
    .pairRise  (pairRise),
    .pairFall  (pairFall),
    .packWord  (packWord),
    .packValid (packValid)
  );

endmodule

// File: rtl/ddrCapture.sv
module ddrCapture
  import ddrCapPkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LANES-1:0]     ddrIn,
  input  logic [1:0]           modeSel,
  output logic [LANES-1:0]     riseWord,
  output logic [LANES-1:0]     fallWord,
  output logic [4*LANES-1:0]   packWord,
  output logic                 packValid
);

  alignMode_t  lockedMode;
  ctrlStrobe_t ctrlStrobe;

  ddrCapCtrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .modeSel    (modeSel),
    .lockedMode (lockedMode),
    .strobe     (ctrlStrobe)
  );

  ddrCapDatapath #(.LANES(LANES)) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .ddrIn     (ddrIn),
    .strobe    (ctrlStrobe),
    .riseWord  (riseWord),
    .fallWord  (fallWord),
    .packWord  (packWord),
    .packValid (packValid)
  );

endmodule

// File: rtl/ddrCapChecker.sv
module ddrCapChecker #(
  parameter int LANES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [LANES-1:0]   ddrIn,
  input logic [1:0]         lockedMode,
  input logic [LANES-1:0]   riseWord,
  input logic [4*LANES-1:0] packWord,
  input logic               packValid
);

  // R1: direct rising path shows the previous edge's sample
  a_r1_rise_direct: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && lockedMode != 2'b10) |-> riseWord == $past(ddrIn));

  // R4: piped rising path lags one more rising edge
  a_r4_rise_piped: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && lockedMode == 2'b10) |-> riseWord == $past(ddrIn, 2));

  // R5: strobe never high two cycles running
  a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
    packValid |=> !packValid);

  // R7: latched mode frozen outside reset
  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(lockedMode));

  // R8: reset clears the packed outputs
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (packWord == '0 && !packValid));

  // R9: packed word unchanged between strobes
  a_r9_pack_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !packValid) |-> $stable(packWord));

endmodule

bind ddrCapture ddrCapChecker #(.LANES(LANES)) u_checker (
  .clk        (clk),
  .rst        (rst),
  .ddrIn      (ddrIn),
  .lockedMode (lockedMode),
  .riseWord   (riseWord),
  .packWord   (packWord),
  .packValid  (packValid)
);

// File: tb/ddrCapture_bench.sv
`timescale 1ns/1ps
module ddrCapture_bench;

  localparam int  N      = 8;
  localparam real PERIOD = 5.0;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   ddrIn = '0;
  logic [1:0]     modeSel = 2'b00;
  logic [N-1:0]   riseWord, fallWord;
  logic [4*N-1:0] packWord;
  logic           packValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [N-1:0]   riseQ[$];
  logic [N-1:0]   fallQ[$];
  int             modelMode;
  logic [4*N-1:0] lastPack;
  string          tagOverride;

  always #(PERIOD/2) clk = ~clk;

  ddrCapture #(.LANES(N)) u_ddrCapture (
    .clk(clk), .rst(rst), .ddrIn(ddrIn), .modeSel(modeSel),
    .riseWord(riseWord), .fallWord(fallWord),
    .packWord(packWord), .packValid(packValid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic string tagOf(input string base);
    return (tagOverride != "") ? tagOverride : base;
  endfunction

  function automatic logic [N-1:0] genVal(input int c, input int salt);
    case ((c + salt) % 3)
      0:       return N'($urandom);
      1:       return N'(1) << ((c + salt) % N);
      default: return ((c % 2) == 0) ? N'('h55) : N'('haa);
    endcase
  endfunction

  task automatic checkPos(input int c);
    logic [N-1:0]   eRise, eFall;
    logic [4*N-1:0] ePack;
    logic           eValid;
    int             lat;
    bit             piped;
    piped = (modelMode == 2);
    lat   = (modelMode == 1 || modelMode == 2) ? 2 : 1;
    eRise = piped ? ((c >= 1) ? riseQ[c-1] : '0) : riseQ[c];
    eFall = (c >= 1) ? fallQ[c-1] : '0;
    eValid = 1'b0;
    ePack  = lastPack;
    if (c >= lat && ((c - lat) % 2) == 1) begin
      int j = c - lat;
      eValid = 1'b1;
      ePack  = {fallQ[j], riseQ[j], fallQ[j-1], riseQ[j-1]};
    end
    chk(tagOf(piped ? "R4 riseWord" : "R1 riseWord"), 64'(riseWord), 64'(eRise));
    chk(tagOf(modelMode == 1 ? "R3 fallWord" : (piped ? "R4 fallWord" : "R2 fallWord")),
        64'(fallWord), 64'(eFall));
    chk(tagOf(c <= lat + 1 ? "R6 packValid" : "R5 packValid"), 64'(packValid), 64'(eValid));
    chk(tagOf(eValid ? "R5 packWord" : "R9 packWord"), 64'(packWord), 64'(ePack));
    lastPack = ePack;
  endtask

  task automatic checkNeg(input int c);
    if (modelMode == 0 || modelMode == 3)
      chk(tagOf("R2 fallWord at falling edge"), 64'(fallWord), 64'(fallQ[c]));
    else
      chk(tagOf("R3 fallWord still at falling edge"), 64'(fallWord),
          64'((c >= 1) ? fallQ[c-1] : N'(0)));
  endtask

  task automatic runMode(input logic [1:0] sel, input int cycles, input int changeAt,
                         input logic [1:0] newSel);
    rst = 1'b1;
    modeSel = sel;
    ddrIn = N'('hc3);
    repeat (2) @(posedge clk);
    #1;
    // R8: cleared while reset is held, despite nonzero input and prior state
    chk("R8 riseWord in reset", 64'(riseWord), 64'(0));
    chk("R8 fallWord in reset", 64'(fallWord), 64'(0));
    chk("R8 packWord in reset", 64'(packWord), 64'(0));
    chk("R8 packValid in reset", 64'(packValid), 64'(0));
    @(negedge clk);
    #1;
    rst = 1'b0;
    modelMode = sel;
    lastPack = '0;
    riseQ.delete();
    fallQ.delete();
    tagOverride = (sel == 2'b11) ? "R7 spare code" : "";
    riseQ.push_back(genVal(0, sel));
    ddrIn = riseQ[0];
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      #1;
      checkPos(c);
      if (c == changeAt) begin
        modeSel = newSel;     // R7: must not take effect
        tagOverride = "R7 mode change ignored";
      end
      fallQ.push_back(genVal(c, sel + 7));
      ddrIn = fallQ[c];
      @(negedge clk);
      #1;
      checkNeg(c);
      riseQ.push_back(genVal(c + 1, sel));
      ddrIn = riseQ[c+1];
    end
  endtask

  initial begin
    tagOverride = "";
    modelMode = 0;
    lastPack = '0;
    runMode(2'b00, 30, 14, 2'b10);
    runMode(2'b01, 30, 12, 2'b00);
    runMode(2'b10, 30, 15, 2'b01);
    runMode(2'b11, 20, 100, 2'b11);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule